// File: doc/BRIEF.md
# Frequency-Window Lock Detector and Loop Mode Controller

This block decides which detector steers a clock-recovery loop. It counts edges of the recovered clock, already divided by 64, over a fixed gate of reference-clock cycles. The reference runs at 1/64 of the line rate, so a perfectly tuned oscillator yields exactly one divided edge per reference cycle. At the end of each gate the block compares the count with the gate length. If the difference is within a tolerance window, the frequency is judged to agree.

When the frequency is outside the window, the loop is in acquisition: the phase-frequency detector must pull the oscillator toward the reference. When it is inside, the loop is in data-tracking mode: the data phase detector drives the charge pump. The block drives a detector-select output and a lock status output. A two-bit select chooses automatic or forced detector choice and a narrow or wide tolerance.

The divided recovered clock and the reference clock are unrelated. The recovered-domain edge count is snapshotted through a toggle request/acknowledge handshake, so the ratio between the two clocks may drift freely. A high reset returns both clock domains to the initial acquisition state.

Top module: `freq_window_lock`

## Requirements
- R1: While `rst` is high, and right after it falls, `lock` is 0. In the automatic modes (`sel[1]`=0), `pfd_sel` is also 1 during that time. `rst` acts asynchronously.
- R2: One measurement counts rising edges of `rec_clk` over `GATE` rising edges of `ref_clk`; its deviation is that count minus `GATE`.
- R3: With `sel[0]`=0 the window is narrow: a deviation of magnitude up to `TOL_NARROW` counts (default 2) is inside, anything larger is outside.
- R4: With `sel[0]`=1 the window is wide: a deviation of magnitude up to `TOL_WIDE` counts (default 8) is inside, anything larger is outside.
- R5: With `sel` = 00 or 01 (automatic), `pfd_sel` is 1 while the latest result is outside the window and 0 while it is inside, so `pfd_sel` is always the inverse of `lock`.
- R6: With `sel` = 10, `pfd_sel` is held at 1 whatever the measurement, and the narrow window applies.
- R7: With `sel` = 11, `pfd_sel` is held at 0 whatever the measurement, and the wide window applies.
- R8: `lock` is 1 exactly when the latest completed measurement was inside the window, in every mode. It changes only when a measurement completes and stays steady while the frequency stays steady.
- R9: The first measurement after reset only sets a starting point. `lock` stays 0 until the second gate after reset has completed.
- R10: A deviation that moves from inside to outside the window returns the loop to acquisition (`lock` 0, and `pfd_sel` 1 in automatic mode) at the next completed measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock at 1/64 of the line rate; drives the gate and all decision logic |
| rec_clk | input | 1 | Recovered clock divided by 64; its edges are counted |
| rst | input | 1 | Global reset, active high, asynchronous |
| sel | input | 2 | Mode select: bit 1 forces the detector choice, bit 0 picks the wide tolerance |
| pfd_sel | output | 1 | 1 when the phase-frequency detector drives the loop, 0 for the data phase detector |
| lock | output | 1 | 1 when the latest measured frequency lies inside the window |

## Verification
The recovered clock is run at rates chosen so the count deviation per gate is zero, a few counts, or many counts, on both the fast and the slow side. Each rate is set well clear of a threshold, so the result does not depend on the ±2-count quantization of the handshake. The same deviations are run under each select code. This separates narrow from wide tolerance (a deviation of 5 or 6 is inside one window and outside the other) and automatic from forced detector choice (the forced codes hold `pfd_sel` against the window result). Between updates `lock` is watched for a whole gate to confirm it holds. Directed runs cover reset during lock and the silent first gate.

// File: rtl/freq_window_lock.sv
module freq_window_lock #(
  parameter int GATE       = 4096,
  parameter int TOL_NARROW = 2,
  parameter int TOL_WIDE   = 8
) (
  input  logic       ref_clk,
  input  logic       rec_clk,
  input  logic       rst,
  input  logic [1:0] sel,
  output logic       pfd_sel,
  output logic       lock
);
  localparam int GW = $clog2(GATE);
  localparam int CW = GW + 2;

  // recovered-clock domain: free edge counter and snapshot on request
  logic [CW-1:0] rec_cnt, snap;
  logic [1:0]    req_sync;
  logic          req_seen, ack_t;

  always_ff @(posedge rec_clk or posedge rst) begin
    if (rst) begin
      rec_cnt  <= '0;
      snap     <= '0;
      req_sync <= '0;
      req_seen <= 1'b0;
      ack_t    <= 1'b0;
    end else begin
      rec_cnt  <= rec_cnt + 1'b1;
      req_sync <= {req_sync[0], req_t};
      req_seen <= req_sync[1];
      if (req_sync[1] != req_seen) begin
        snap  <= rec_cnt;
        ack_t <= req_sync[1];
      end
    end
  end

  // reference domain: gate timer and handshake
  logic [GW-1:0] gate_cnt;
  logic          req_t, waiting;
  logic [1:0]    ack_sync;
  logic          ack_seen;
  wire           gate_end  = (gate_cnt == GW'(GATE - 1));
  wire           meas_fire = ack_sync[1] ^ ack_seen;

  always_ff @(posedge ref_clk or posedge rst) begin
    if (rst) begin
      gate_cnt <= '0;
      req_t    <= 1'b0;
      waiting  <= 1'b0;
      ack_sync <= '0;
      ack_seen <= 1'b0;
    end else begin
      gate_cnt <= gate_end ? '0 : gate_cnt + 1'b1;
      ack_sync <= {ack_sync[0], ack_t};
      ack_seen <= ack_sync[1];
      if (gate_end && !waiting) begin
        req_t   <= ~req_t;
        waiting <= 1'b1;
      end else if (meas_fire) begin
        waiting <= 1'b0;
      end
    end
  end

  // window decision
  logic [CW-1:0]        prev;
  logic                 primed, win_ok;
  wire  [CW-1:0]        diff = snap - prev;
  wire  signed [CW:0]   dev  = $signed({1'b0, diff}) - $signed((CW+1)'(GATE));
  wire  [CW:0]          mag  = dev[CW] ? (CW+1)'(-dev) : (CW+1)'(dev);
  wire  [CW:0]          tol  = sel[0] ? (CW+1)'(TOL_WIDE) : (CW+1)'(TOL_NARROW);
  wire                  in_win = (mag <= tol);

  always_ff @(posedge ref_clk or posedge rst) begin
    if (rst) begin
      prev   <= '0;
      primed <= 1'b0;
      win_ok <= 1'b0;
    end else if (meas_fire) begin
      prev   <= snap;
      primed <= 1'b1;
      if (primed) win_ok <= in_win;
    end
  end

  assign lock    = win_ok;
  assign pfd_sel = sel[1] ? ~sel[0] : ~win_ok;

  p_no_overlap_r2: assert property (@(posedge ref_clk) disable iff (rst)
    gate_end |-> !waiting || meas_fire);
  p_single_fire_r2: assert property (@(posedge ref_clk) disable iff (rst)
    meas_fire |=> !meas_fire);
  p_auto_inverse_r5: assert property (@(posedge ref_clk) disable iff (rst)
    !sel[1] |-> (pfd_sel != lock));
  p_force_pfd_r6: assert property (@(posedge ref_clk) disable iff (rst)
    (sel == 2'b10) |-> pfd_sel);
  p_force_dpd_r7: assert property (@(posedge ref_clk) disable iff (rst)
    (sel == 2'b11) |-> !pfd_sel);
  p_lock_steady_r8: assert property (@(posedge ref_clk) disable iff (rst)
    !meas_fire |=> $stable(lock));
  p_unprimed_r9: assert property (@(posedge ref_clk) disable iff (rst)
    !primed |-> !lock);
endmodule

// File: tb/tb_freq_window_lock.sv
`timescale 1ns/1ps
module tb_freq_window_lock;
  localparam int GATE = 256;
  localparam int TN = 2;
  localparam int TW = 8;
  localparam int NV = 13;
  // R2: deviation per gate is set through the recovered-clock period
  localparam int          VD [NV] = '{0, 6, -6, 6, -5, 14, -14, 0, 14, -14, 5, 0, 0};
  localparam logic [1:0]  VS [NV] = '{2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 2'b01,
                                      2'b10, 2'b10, 2'b11, 2'b11, 2'b11, 2'b00};

  logic ref_clk = 1'b0, rec_clk = 1'b0, rst = 1'b1;
  logic [1:0] sel = 2'b00;
  logic pfd_sel, lock;
  real  rec_half = 10.0;
  int   checks = 0, errors = 0;

  freq_window_lock #(.GATE(GATE), .TOL_NARROW(TN), .TOL_WIDE(TW)) dut (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst(rst), .sel(sel),
    .pfd_sel(pfd_sel), .lock(lock));

  always #10 ref_clk = ~ref_clk;
  initial forever #(rec_half) rec_clk = ~rec_clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(5);
    chk("R1 lock in reset", lock, 1'b0);
    chk("R1 pfd_sel in reset", pfd_sel, 1'b1);
    rst = 1'b0;
    cyc(300);
    chk("R9 lock after first gate", lock, 1'b0);
    chk("R9 pfd_sel after first gate", pfd_sel, 1'b1);

    for (int i = 0; i < NV; i++) begin
      int d, ad, tol, changes;
      logic inw, epfd, prev_lock;
      string tag;
      d   = VD[i];
      ad  = (d < 0) ? -d : d;
      tol = VS[i][0] ? TW : TN;
      inw = (ad <= tol);
      epfd = VS[i][1] ? ~VS[i][0] : ~inw;
      tag = VS[i][1] ? (VS[i][0] ? "R7" : "R6") : (VS[i][0] ? "R4" : "R3");
      sel = VS[i];
      rec_half = 10.0 * real'(GATE) / real'(GATE + d);
      cyc(3 * GATE);
      // R10 covered when vector 1 leaves the window reached in vector 0
      chk($sformatf("%s/R8 lock vec %0d", tag, i), lock, inw);
      chk($sformatf("%s/R5 pfd_sel vec %0d", tag, i), pfd_sel, epfd);
      changes = 0;
      prev_lock = lock;
      for (int k = 0; k < GATE; k++) begin
        cyc(1);
        if (lock !== prev_lock) changes++;
        prev_lock = lock;
      end
      chk($sformatf("R8 lock steady vec %0d", i), changes == 0, 1'b1);
    end

    // R10 directed: in window, then out, under automatic narrow tolerance
    chk("R10 locked before step", lock, 1'b1);
    rec_half = 10.0 * real'(GATE) / real'(GATE + 10);
    cyc(3 * GATE);
    chk("R10 lock after step out", lock, 1'b0);
    chk("R10 pfd_sel after step out", pfd_sel, 1'b1);
    rec_half = 10.0;
    cyc(3 * GATE);
    chk("R5 relock", lock, 1'b1);

    // R1 mid-run reset, R9 silent first gate
    rst = 1'b1;
    #1;
    chk("R1 lock async reset", lock, 1'b0);
    chk("R1 pfd_sel async reset", pfd_sel, 1'b1);
    cyc(3);
    rst = 1'b0;
    cyc(GATE + 40);
    chk("R9 lock before second gate", lock, 1'b0);
    cyc(2 * GATE);
    chk("R9 lock after second gate", lock, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule